// File: doc/BRIEF.md
# Configurable Logic Block

This block is one programmable logic cell of a small programmable-logic fabric. Eighteen logic inputs feed a shared pool of product terms. Each term is an AND of input literals picked by configuration. Four macrocells build their logic values from this pool. A macrocell can take a wide OR of any subset of the first twenty terms, followed by a polarity inversion. It can instead take a narrow four-term OR that skips the inversion. Each macrocell then presents that value directly or through its own register.

Three more product terms serve as the block's control terms: a locally generated clock, an asynchronous clear, and an output enable. The block registers share one clock, which configuration chooses from three global clock inputs or the clock term. All global and configured clocks are treated as signals sampled on the fabric clock `clk`. A register loads on the `clk` edge at which its selected source is seen rising. The configuration is a set of static input vectors held by the surrounding fabric.

Top module: `pldb_block`

## Requirements
- R1: Product term t takes its literal codes from `cfg_and[t*36 +: 36]`, two bits per input i at bit offset 2*i. Code 00 leaves the input out, 01 uses the input true, 10 uses it inverted, and 11 forces the term to 0. A term with no literal in use is 0.
- R2: With its fast bit clear, macrocell m ORs the terms 0..19 whose bits are set in `cfg_sum[m*20 +: 20]` and XORs the result with `cfg_inv[m]`. An empty selection therefore gives `cfg_inv[m]`.
- R3: With `cfg_fast[m]` set, the logic value of macrocell m is the OR of terms 4m..4m+3. `cfg_inv[m]` and the selection mask have no effect on it.
- R4: With `cfg_comb[m]` set, `mc_out[m]` follows the logic value with no clock involved.
- R5: With `cfg_comb[m]` clear, `mc_out[m]` shows a register. The register loads the logic value on the `clk` edge where the selected clock source is high and was low at the previous edge. It holds at every other edge.
- R6: `cfg_clk` values 0, 1 and 2 select `gclk[0]`, `gclk[1]` and `gclk[2]`. Value 3 selects product term 20. Unselected clocks have no effect.
- R7: `gres_n` low clears every register at once, without waiting for a clock edge.
- R8: Product term 21 high clears every register at once, and this clear wins over a coinciding load edge.
- R9: `mc_oe` equals product term 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock on which all clock sources are sampled |
| gres_n | input | 1 | Active-low global clear, asynchronous |
| gclk | input | 3 | Global clock sources |
| din | input | 18 | Logic inputs to the product-term array |
| cfg_and | input | 828 | Literal codes, 23 terms of 36 bits |
| cfg_sum | input | 80 | Wide-sum term selection, 20 bits per macrocell |
| cfg_inv | input | 4 | Polarity bit per macrocell |
| cfg_fast | input | 4 | Selects the four-term path per macrocell |
| cfg_comb | input | 4 | Bypasses the register per macrocell |
| cfg_clk | input | 2 | Clock source select |
| mc_out | output | 4 | Macrocell outputs |
| mc_oe | output | 1 | Output enable from the enable term |

## Verification
A wrong literal decode or sum selection shows at once on a combinatorial output, in the same cycle the inputs are applied. A register that loads on the wrong edge, misses a load or misses a clear shows on a registered output one `clk` edge later. From then on it persists until the next real load, so a bench that compares each cycle catches it within a cycle. A fault in the edge detector for the selected source shows up as a load with the clock held high, or as a load on an unselected clock. Both are visible on the first edge after the stimulus.

// File: rtl/pldb_pkg.sv
package pldb_pkg;
   typedef enum logic [1:0] {
      LIT_OFF  = 2'b00,
      LIT_TRUE = 2'b01,
      LIT_INV  = 2'b10,
      LIT_KILL = 2'b11
   } lit_e;

   // Control terms follow the sum terms in this order.
   localparam int CTRL_TERMS = 3;
   localparam int CT_CLK     = 0;
   localparam int CT_RST     = 1;
   localparam int CT_OE      = 2;
endpackage

// File: rtl/pldb_terms.sv
module pldb_terms
   import pldb_pkg::*;
#(
   parameter int NIN = 18,
   parameter int NT  = 23
)(
   input  logic [NIN-1:0]      din,
   input  logic [NT*2*NIN-1:0] cfg_and,
   output logic [NT-1:0]       term
);
   if (NIN < 1) begin : g_bad_nin
      $error("pldb_terms: NIN must be at least 1");
   end

   for (genvar t = 0; t < NT; t++) begin : g_term
      logic [2*NIN-1:0] fld;
      logic [NIN-1:0]   keep;
      logic [NIN-1:0]   used;

      assign fld = cfg_and[t*2*NIN +: 2*NIN];

      always_comb begin
         for (int i = 0; i < NIN; i++) begin
            unique case (lit_e'(fld[2*i +: 2]))
               LIT_OFF:  begin keep[i] = 1'b1;    used[i] = 1'b0; end
               LIT_TRUE: begin keep[i] = din[i];  used[i] = 1'b1; end
               LIT_INV:  begin keep[i] = ~din[i]; used[i] = 1'b1; end
               LIT_KILL: begin keep[i] = 1'b0;    used[i] = 1'b1; end
            endcase
         end
      end

      assign term[t] = (|used) & (&keep);
   end
endmodule

// File: rtl/pldb_clksel.sv
module pldb_clksel #(
   parameter int NGCLK = 3,
   parameter int CKW   = 2
)(
   input  logic             clk,
   input  logic             gres_n,
   input  logic [NGCLK-1:0] gclk,
   input  logic             pt_clk,
   input  logic             pt_rst,
   input  logic [CKW-1:0]   cfg_clk,
   output logic             ld_en,
   output logic             rst_any
);
   if (NGCLK < 1 || (1 << CKW) < NGCLK + 1) begin : g_bad_ck
      $error("pldb_clksel: select width too small for clock count");
   end

   logic src, src_q;

   always_comb begin
      if (int'(cfg_clk) < NGCLK) src = gclk[cfg_clk];
      else                       src = pt_clk;
   end

   always_ff @(posedge clk or negedge gres_n) begin
      if (!gres_n) src_q <= 1'b0;
      else         src_q <= src;
   end

   assign ld_en   = src & ~src_q;
   assign rst_any = ~gres_n | pt_rst;

   // R5: two loads in consecutive cycles need a fall in between
   p_single_edge_r5: assert property (@(posedge clk) disable iff (!gres_n)
      ld_en |=> !ld_en);
endmodule

// File: rtl/pldb_mcell.sv
module pldb_mcell #(
   parameter int NPT     = 20,
   parameter int FAST_W  = 4,
   parameter int FAST_LO = 0
)(
   input  logic           clk,
   input  logic           gres_n,
   input  logic           rst_any,
   input  logic           pt_rst,
   input  logic           ld_en,
   input  logic [NPT-1:0] term,
   input  logic [NPT-1:0] alloc,
   input  logic           inv,
   input  logic           fast,
   input  logic           comb,
   output logic           q_out
);
   if (FAST_W > 0 && FAST_LO + FAST_W > NPT) begin : g_bad_fast
      $error("pldb_mcell: fast group outside the term pool");
   end

   logic wide, quick, d, q;

   assign wide = (|(term & alloc)) ^ inv;

   if (FAST_W > 0) begin : g_fast
      assign quick = |term[FAST_LO +: FAST_W];
   end else begin : g_nofast
      assign quick = 1'b0;
   end

   assign d = fast ? quick : wide;

   always_ff @(posedge clk or posedge rst_any) begin
      if (rst_any)    q <= 1'b0;
      else if (ld_en) q <= d;
   end

   assign q_out = comb ? d : q;

   // R5: a load edge captures the logic value
   p_load_r5: assert property (@(posedge clk) disable iff (!gres_n)
      (ld_en && !rst_any) |=> (rst_any || q == $past(d)));
   // R5: no edge, no change
   p_hold_r5: assert property (@(posedge clk) disable iff (!gres_n)
      (!ld_en && !rst_any) |=> (rst_any || $stable(q)));
   // R8: term clear wins over any edge
   p_ptrst_clear_r8: assert property (@(posedge clk) disable iff (!gres_n)
      pt_rst |-> (q == 1'b0));
   // R7: global clear holds the register at zero
   p_grst_clear_r7: assert property (@(posedge clk)
      !gres_n |-> (q == 1'b0));
endmodule

// File: rtl/pldb_block.sv
module pldb_block
   import pldb_pkg::*;
#(
   parameter  int NIN    = 18,
   parameter  int NPT    = 20,
   parameter  int NMC    = 4,
   parameter  int FAST_W = 4,
   parameter  int NGCLK  = 3,
   localparam int NT     = NPT + CTRL_TERMS,
   localparam int CKW    = $clog2(NGCLK + 1)
)(
   input  logic               clk,
   input  logic               gres_n,
   input  logic [NGCLK-1:0]   gclk,
   input  logic [NIN-1:0]     din,
   input  logic [NT*2*NIN-1:0] cfg_and,
   input  logic [NMC*NPT-1:0] cfg_sum,
   input  logic [NMC-1:0]     cfg_inv,
   input  logic [NMC-1:0]     cfg_fast,
   input  logic [NMC-1:0]     cfg_comb,
   input  logic [CKW-1:0]     cfg_clk,
   output logic [NMC-1:0]     mc_out,
   output logic               mc_oe
);
   if (NMC < 1 || NPT < NMC * FAST_W) begin : g_bad_pool
      $error("pldb_block: term pool too small for the fast groups");
   end

   logic [NT-1:0] term;
   logic          ld_en, rst_any;

   pldb_terms #(.NIN(NIN), .NT(NT)) u_terms (
      .din     (din),
      .cfg_and (cfg_and),
      .term    (term)
   );

   pldb_clksel #(.NGCLK(NGCLK), .CKW(CKW)) u_clksel (
      .clk     (clk),
      .gres_n  (gres_n),
      .gclk    (gclk),
      .pt_clk  (term[NPT+CT_CLK]),
      .pt_rst  (term[NPT+CT_RST]),
      .cfg_clk (cfg_clk),
      .ld_en   (ld_en),
      .rst_any (rst_any)
   );

   for (genvar m = 0; m < NMC; m++) begin : g_mc
      pldb_mcell #(.NPT(NPT), .FAST_W(FAST_W), .FAST_LO(m*FAST_W)) u_mc (
         .clk     (clk),
         .gres_n  (gres_n),
         .rst_any (rst_any),
         .pt_rst  (term[NPT+CT_RST]),
         .ld_en   (ld_en),
         .term    (term[NPT-1:0]),
         .alloc   (cfg_sum[m*NPT +: NPT]),
         .inv     (cfg_inv[m]),
         .fast    (cfg_fast[m]),
         .comb    (cfg_comb[m]),
         .q_out   (mc_out[m])
      );
   end

   assign mc_oe = term[NPT+CT_OE];

   // R9: an enable term with no literals keeps the enable off
   p_oe_empty_r9: assert property (@(posedge clk) disable iff (!gres_n)
      (cfg_and[(NPT+CT_OE)*2*NIN +: 2*NIN] == '0) |-> !mc_oe);
endmodule

// File: tb/pldb_block_bench.sv
module pldb_block_bench;
   localparam int NIN = 18, NPT = 20, NMC = 4, NT = 23;
   localparam int TW  = 2*NIN;

   logic clk = 1'b0;
   logic gres_n;
   logic [2:0]         gclk;
   logic [NIN-1:0]     din;
   logic [NT*TW-1:0]   cfg_and;
   logic [NMC*NPT-1:0] cfg_sum;
   logic [NMC-1:0]     cfg_inv, cfg_fast, cfg_comb;
   logic [1:0]         cfg_clk;
   logic [NMC-1:0]     mc_out;
   logic               mc_oe;

   int checks = 0, errors = 0;
   logic [NMC-1:0] m_q;
   logic           m_prev;

   always #5 clk = ~clk;

   pldb_block u_pldb_block (
      .clk(clk), .gres_n(gres_n), .gclk(gclk), .din(din),
      .cfg_and(cfg_and), .cfg_sum(cfg_sum), .cfg_inv(cfg_inv),
      .cfg_fast(cfg_fast), .cfg_comb(cfg_comb), .cfg_clk(cfg_clk),
      .mc_out(mc_out), .mc_oe(mc_oe)
   );

   // {gclk[2:0], din[17:0]}
   localparam logic [20:0] VEC [16] = '{
      21'h000000, 21'h1C0001, 21'h02AAAA, 21'h1D5555,
      21'h03FFFF, 21'h1C0000, 21'h012345, 21'h1DCBA9,
      21'h000F0F, 21'h0A0F0F, 21'h000003, 21'h14F00F,
      21'h00FF00, 21'h1FFFFF, 21'h024680, 21'h1E1357
   };

   function automatic logic [NT-1:0] ref_terms(input logic [NIN-1:0] x);
      logic [NT-1:0] r;
      for (int t = 0; t < NT; t++) begin
         logic any, ok;
         any = 1'b0; ok = 1'b1;
         for (int i = 0; i < NIN; i++) begin
            case (cfg_and[t*TW + 2*i +: 2])
               2'b01: begin any = 1'b1; if (!x[i]) ok = 1'b0; end
               2'b10: begin any = 1'b1; if (x[i])  ok = 1'b0; end
               2'b11: begin any = 1'b1; ok = 1'b0; end
               default: ;
            endcase
         end
         r[t] = any & ok;
      end
      return r;
   endfunction

   function automatic logic [NMC-1:0] ref_logic(input logic [NT-1:0] tm);
      logic [NMC-1:0] r;
      for (int m = 0; m < NMC; m++) begin
         if (cfg_fast[m]) r[m] = |tm[4*m +: 4];
         else r[m] = (|(tm[NPT-1:0] & cfg_sum[m*NPT +: NPT])) ^ cfg_inv[m];
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic set_lit(input int t, input int i, input logic [1:0] code);
      cfg_and[t*TW + 2*i +: 2] = code;
   endtask

   task automatic clear_cfg();
      cfg_and = '0; cfg_sum = '0; cfg_inv = '0;
      cfg_fast = '0; cfg_comb = '0; cfg_clk = 2'd0;
   endtask

   // Drive at the falling edge, evaluate the model after the next rising edge.
   task automatic step(input string req, input logic [NIN-1:0] x, input logic [2:0] g);
      logic [NT-1:0]  tm;
      logic [NMC-1:0] lg, ex;
      logic           src;
      @(negedge clk); din = x; gclk = g;
      @(posedge clk); #1;
      tm = ref_terms(x);
      lg = ref_logic(tm);
      src = (cfg_clk == 2'd3) ? tm[NPT] : g[cfg_clk];
      if (tm[NPT+1]) m_q = '0;
      else if (src && !m_prev) m_q = lg;
      m_prev = src;
      ex = (cfg_comb & lg) | (~cfg_comb & m_q);
      chk(req, mc_out, ex);
      chk({req, " oe R9"}, mc_oe, tm[NPT+2]);
   endtask

   function automatic logic [1:0] rnd_lit();
      int unsigned r;
      r = $urandom_range(31, 0);
      if (r < 26) return 2'b00;
      if (r < 29) return 2'b01;
      if (r < 31) return 2'b10;
      return 2'b11;
   endfunction

   initial begin
      #(200000 * 10);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      gres_n = 1'b0; din = '0; gclk = '0;
      clear_cfg();
      m_q = '0; m_prev = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R7 reset state", mc_out, 8'h0);
      chk("R9 empty enable term", mc_oe, 8'h0);
      gres_n = 1'b1;

      // R1 R2 R3 R4: combinatorial decode
      cfg_comb = 4'hF;
      cfg_fast = 4'b1001;
      cfg_inv  = 4'b1100;
      set_lit(0, 0, 2'b01); set_lit(0, 1, 2'b10);
      set_lit(1, 2, 2'b11); set_lit(1, 3, 2'b01);
      cfg_sum[1*NPT + 0] = 1'b1;
      cfg_sum[3*NPT +: NPT] = '1;
      step("R1 R4 literals", 18'h00001, 3'b000);
      chk("R1 R2 R3 pattern 1", mc_out, 8'h7);
      step("R1 R4 literals", 18'h00003, 3'b000);
      chk("R1 R2 R3 inverted literal", mc_out, 8'h4);
      step("R1 kill code", 18'h0000D, 3'b000);
      chk("R1 kill code term stays 0", mc_out, 8'h7);

      // R5 R6: registered on global clock 1
      cfg_comb = 4'h0; cfg_clk = 2'd1;
      step("R5 no edge", 18'h00001, 3'b000);
      chk("R5 no edge", mc_out, 8'h0);
      step("R5 load", 18'h00001, 3'b010);
      chk("R5 load on rise", mc_out, 8'h7);
      step("R5 hold high", 18'h00003, 3'b010);
      chk("R5 held clock high", mc_out, 8'h7);
      step("R6 other clocks", 18'h00003, 3'b101);
      chk("R6 unselected clocks ignored", mc_out, 8'h7);
      step("R5 second load", 18'h00003, 3'b010);
      chk("R5 second load", mc_out, 8'h4);

      // R6: product-term clock on din[4]
      cfg_clk = 2'd3;
      set_lit(NPT, 4, 2'b01);
      step("R6 term clock low", 18'h00001, 3'b000);
      chk("R6 term clock low", mc_out, 8'h4);
      step("R6 term clock rise", 18'h00011, 3'b111);
      chk("R6 term clock rise", mc_out, 8'h7);

      // R8: product-term clear on din[17]
      set_lit(NPT+1, 17, 2'b01);
      din = 18'h20011; #1;
      chk("R8 asynchronous term clear", mc_out, 8'h0);
      m_q = '0;
      step("R8 clear held", 18'h20001, 3'b000);
      step("R8 clear beats edge", 18'h20011, 3'b000);
      chk("R8 clear beats edge", mc_out, 8'h0);
      step("R8 released", 18'h00001, 3'b000);
      step("R8 load after release", 18'h00011, 3'b000);
      chk("R8 load after release", mc_out, 8'h7);
      set_lit(NPT+1, 17, 2'b00);

      // R7: global clear without a clock edge
      gres_n = 1'b0; #1;
      chk("R7 asynchronous global clear", mc_out, 8'h0);
      @(posedge clk); #1;
      chk("R7 clear through edge", mc_out, 8'h0);
      gres_n = 1'b1; m_q = '0; m_prev = 1'b0;

      // R9: enable term on inverted din[5]
      set_lit(NPT+2, 5, 2'b10);
      step("R9 enable", 18'h00000, 3'b000);
      chk("R9 enable high", mc_oe, 8'h1);
      step("R9 enable", 18'h00020, 3'b000);
      chk("R9 enable low", mc_oe, 8'h0);

      // R2 R3 R4 R5 R6: random configurations over the vector table
      for (int c = 0; c < 8; c++) begin
         for (int t = 0; t < NT; t++)
            for (int i = 0; i < NIN; i++)
               set_lit(t, i, (t < NPT || t == NPT+2) ? rnd_lit() : 2'b00);
         set_lit(NPT, 0, 2'b01);
         cfg_sum  = {$urandom, $urandom, $urandom};
         cfg_inv  = 4'($urandom);
         cfg_fast = 4'($urandom);
         cfg_comb = 4'($urandom);
         cfg_clk  = 2'(c);
         for (int k = 0; k < 16; k++)
            step("R2 R3 R4 R5 R6 random", VEC[k][17:0], VEC[k][20:18]);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule